// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Datapath

This block is a 32-bit processor core that finishes every instruction in a single rising clock edge. It holds a program counter, a 32-entry register file with two combinational read ports and one write port, an ALU, a sign extender, and word-addressed instruction and data memories. A decoder looks at the opcode and function fields and drives the register write, memory write, ALU selection and next-PC selection. The core executes nine instructions: load word, store word, add, subtract, and, or, set-on-less-than, branch-if-equal and jump.

Both memories are filled through one load port while the core is held in reset. After reset is released, the core fetches from address 0 and runs. Its register write-back strobe and data-memory store strobe are brought out as outputs, so a testbench or a neighbouring block can follow every state change.

Top module: `sc_core`

## Requirements
- R1: `rst` is synchronous. A rising edge with `rst` high sets `pc` to 0 and clears all 32 registers. While `rst` is high, `wb_en` and `st_en` stay low. Reset leaves the contents of both memories unchanged.
- R2: Instruction fields are: opcode at [31:26], rs at [25:21], rt at [20:16], rd at [15:11], function at [5:0], immediate at [15:0] and jump target at [25:0]. Opcode 0x00 selects register-register operations. Function 0x20 adds, 0x22 subtracts (rs minus rt), 0x24 ANDs and 0x25 ORs. The result is written to rd on the next edge, and `pc` advances by 4.
- R3: Opcode 0x00 with function 0x2A writes 1 to rd when rs is less than rt as signed two's-complement values. Otherwise it writes 0.
- R4: Opcode 0x23 (load word) forms the address rs + sign-extended immediate. It reads the data word at index address[DAW+1:2] and writes that word to rt.
- R5: Opcode 0x2B (store word) writes rt to the data word at index address[DAW+1:2], with the address formed as in R4. During that cycle `st_en` is high, `st_addr` shows the full address and `st_data` shows the rt value. `wb_en` stays low and no register changes.
- R6: Opcode 0x04 (branch-if-equal) sets the next PC to pc+4 + (sign-extended immediate << 2) when rs equals rt. Otherwise the next PC is pc+4. No register or memory is written.
- R7: Opcode 0x02 (jump) sets the next PC to {(pc+4)[31:28], target, 2'b00}.
- R8: The following run as no-ops that only advance `pc` by 4: any other opcode, and opcode 0x00 with a function code outside R2 and R3.
- R9: Register 0 always reads as 0. An instruction whose destination is register 0 changes no state and keeps `wb_en` low.
- R10: The instruction executed is the instruction-memory word at index pc[IAW+1:2]. When `load_we` is high at a rising edge, the load port writes `load_data` into the word at `load_addr`. `load_dmem`=1 selects data memory and `load_dmem`=0 selects instruction memory. `pc` is always word aligned.
- R11: `wb_en`, `wb_reg` and `wb_data` show, combinationally, the register write that the current instruction commits at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_we | input | 1 | Memory load strobe |
| load_dmem | input | 1 | Load target: 1 = data memory, 0 = instruction memory |
| load_addr | input | LAW | Word index for the load port |
| load_data | input | 32 | Word to load |
| pc | output | 32 | Current program counter |
| wb_en | output | 1 | Register write this cycle |
| wb_reg | output | 5 | Destination register of the write |
| wb_data | output | 32 | Value being written |
| st_en | output | 1 | Data-memory store this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word being stored |

## Verification
A directed program runs first on preloaded signed extremes. It separates signed from unsigned comparison, sign-extended offsets from zero-extended ones, a taken branch from one that is not taken, and a real write from a write to register 0. It also covers a store followed by a read-back from the same wrapped address. Three random programs follow. They draw from a narrow register range, so values depend on earlier results, and they mix in unsupported opcodes and function codes, which shows whether those codes are really inert. The later programs start from the data memory left behind by the earlier ones, which shows that reset clears the registers but leaves the memories untouched.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_we,
  input  logic           load_dmem,
  input  logic [LAW-1:0] load_addr,
  input  logic [31:0]    load_data,
  output logic [31:0]    pc,
  output logic           wb_en,
  output logic [4:0]     wb_reg,
  output logic [31:0]    wb_data,
  output logic           st_en,
  output logic [31:0]    st_addr,
  output logic [31:0]    st_data
);

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf [32];

  logic [31:0] instr, rs_val, rt_val, imm_sx, alu_b, alu_y, pc_plus4, pc_next, ld_val;
  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd;
  logic        fn_ok, is_r, is_lw, is_sw, is_beq, is_j, zero;

  assign instr = imem[pc[IAW+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign fn    = instr[5:0];

  assign fn_ok  = (fn == 6'h20) || (fn == 6'h22) || (fn == 6'h24) || (fn == 6'h25) || (fn == 6'h2A);
  assign is_r   = (op == 6'h00) && fn_ok;
  assign is_lw  = (op == 6'h23);
  assign is_sw  = (op == 6'h2B);
  assign is_beq = (op == 6'h04);
  assign is_j   = (op == 6'h02);

  assign imm_sx = {{16{instr[15]}}, instr[15:0]};
  assign rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign alu_b  = (is_lw || is_sw) ? imm_sx : rt_val;

  always_comb begin
    alu_y = rs_val + alu_b;
    if (is_beq || (is_r && fn == 6'h22))
      alu_y = rs_val - alu_b;
    else if (is_r && fn == 6'h24)
      alu_y = rs_val & alu_b;
    else if (is_r && fn == 6'h25)
      alu_y = rs_val | alu_b;
    else if (is_r && fn == 6'h2A)
      alu_y = {31'd0, $signed(rs_val) < $signed(alu_b)};
  end

  assign zero     = (alu_y == 32'd0);
  assign pc_plus4 = pc + 32'd4;
  assign pc_next  = is_j             ? {pc_plus4[31:28], instr[25:0], 2'b00} :
                    (is_beq && zero) ? pc_plus4 + {imm_sx[29:0], 2'b00} :
                                       pc_plus4;

  assign ld_val  = dmem[alu_y[DAW+1:2]];
  assign wb_reg  = is_lw ? rt : rd;
  assign wb_en   = !rst && (is_r || is_lw) && (wb_reg != 5'd0);
  assign wb_data = is_lw ? ld_val : alu_y;
  assign st_en   = !rst && is_sw;
  assign st_addr = alu_y;
  assign st_data = rt_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      pc <= pc_next;
      if (wb_en) rf[wb_reg] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (st_en) dmem[alu_y[DAW+1:2]] <= rt_val;
    if (load_we && load_dmem) dmem[load_addr[DAW-1:0]] <= load_data;
    if (load_we && !load_dmem) imem[load_addr[IAW-1:0]] <= load_data;
  end

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        wb_en,
  input logic [4:0]  wb_reg,
  input logic        st_en
);

  p_pc_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == 32'd0);

  p_lw_dest_r4: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'h23 && instr[20:16] != 5'd0) |-> (wb_en && wb_reg == instr[20:16]));

  p_store_no_wb_r5: assert property (@(posedge clk) disable iff (rst)
    st_en |-> !wb_en);

  p_jump_r7: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'h02) |=> pc[27:2] == $past(instr[25:0]));

  p_seq_pc_r8: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] != 6'h02 && instr[31:26] != 6'h04) |=> pc == $past(pc) + 32'd4);

  p_pc_align_r10: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .instr(instr),
  .wb_en(wb_en), .wb_reg(wb_reg), .st_en(st_en)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;
  localparam int PERIOD = 10;
  localparam int IMEM_WORDS = 64;
  localparam int DMEM_WORDS = 64;
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam int LAW = (IAW > DAW) ? IAW : DAW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_we = 1'b0, load_dmem = 1'b0;
  logic [LAW-1:0] load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc, wb_data, st_addr, st_data;
  logic [4:0]  wb_reg;
  logic        wb_en, st_en;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_rf [32];
  logic [31:0] m_dm [DMEM_WORDS];
  logic [31:0] m_im [IMEM_WORDS];
  logic [31:0] m_pc;
  string prev_tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  sc_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_sc_core (
    .clk(clk), .rst(rst), .load_we(load_we), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data), .pc(pc),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data));

  function automatic logic [31:0] rtype(logic [4:0] s, logic [4:0] t, logic [4:0] d, logic [5:0] f);
    return {6'h00, s, t, d, 5'd0, f};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] o, logic [4:0] s, logic [4:0] t, logic [15:0] imm);
    return {o, s, t, imm};
  endfunction
  function automatic logic [31:0] jtype(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  function automatic logic [31:0] ref_alu(logic [5:0] f, logic [31:0] a, logic [31:0] b);
    case (f)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] rand_word();
    int k = $urandom_range(0, 9);
    logic [4:0] a = 5'($urandom_range(0, 7));
    logic [4:0] b = 5'($urandom_range(0, 7));
    logic [4:0] c = 5'($urandom_range(0, 7));
    logic [15:0] imm = 16'($urandom_range(0, 63)) - 16'd32;
    case (k)
      0: return rtype(a, b, c, 6'h20);
      1: return rtype(a, b, c, 6'h22);
      2: return rtype(a, b, c, 6'h24);
      3: return rtype(a, b, c, 6'h25);
      4: return rtype(a, b, c, 6'h2A);
      5: return itype(6'h23, a, b, imm);
      6: return itype(6'h2B, a, b, imm);
      7: return itype(6'h04, a, b, imm);
      8: return jtype(26'($urandom_range(0, IMEM_WORDS - 1)));
      default: begin
        case ($urandom_range(0, 3))
          0: return itype(6'h3F, a, b, imm);
          1: return itype(6'h08, a, b, imm);
          2: return rtype(a, b, c, 6'h21);
          default: return rtype(a, b, c, 6'h00);
        endcase
      end
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic load_word(input bit to_d, input int idx, input logic [31:0] w);
    @(negedge clk);
    load_we = 1'b1;
    load_dmem = to_d;
    load_addr = LAW'(idx);
    load_data = w;
  endtask

  task automatic start_program(input bit fill_dmem);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < IMEM_WORDS; i++) load_word(1'b0, i, m_im[i]);
    if (fill_dmem)
      for (int i = 0; i < DMEM_WORDS; i++) load_word(1'b1, i, m_dm[i]);
    @(negedge clk);
    load_we = 1'b0;
    #1;
    chk(pc === 32'd0, "R1", "pc in reset", pc, 32'd0);
    chk(!wb_en && !st_en, "R1", "strobes in reset", 32'({wb_en, st_en}), 32'd0);
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    m_pc = 32'd0;
    prev_tag = "R1";
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    logic [31:0] ins, a, b, sx, y, npc, e_wd, e_sa, e_sd;
    logic [4:0]  e_wr;
    logic        e_we, e_se;
    string       tag;
    ins  = m_im[m_pc[IAW+1:2]];
    a    = m_rf[ins[25:21]];
    b    = m_rf[ins[20:16]];
    sx   = {{16{ins[15]}}, ins[15:0]};
    npc  = m_pc + 32'd4;
    e_we = 1'b0; e_se = 1'b0; e_wr = 5'd0; e_wd = 32'd0; e_sa = 32'd0; e_sd = 32'd0;
    tag  = "R8";
    case (ins[31:26])
      6'h00: if (ins[5:0] inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A}) begin
        e_we = 1'b1; e_wr = ins[15:11]; e_wd = ref_alu(ins[5:0], a, b);
        tag = (ins[5:0] == 6'h2A) ? "R3" : "R2";
      end
      6'h23: begin
        y = a + sx;
        e_we = 1'b1; e_wr = ins[20:16]; e_wd = m_dm[y[DAW+1:2]]; tag = "R4";
      end
      6'h2B: begin e_se = 1'b1; e_sa = a + sx; e_sd = b; tag = "R5"; end
      6'h04: begin if (a == b) npc = npc + {sx[29:0], 2'b00}; tag = "R6"; end
      6'h02: begin npc = {npc[31:28], ins[25:0], 2'b00}; tag = "R7"; end
      default: ;
    endcase
    if (e_we && e_wr == 5'd0) begin e_we = 1'b0; tag = "R9"; end

    chk(pc === m_pc, {prev_tag, "/R10"}, "pc", pc, m_pc);
    chk(wb_en === e_we, tag, "wb_en", 32'(wb_en), 32'(e_we));
    if (e_we) begin
      chk(wb_reg === e_wr, {tag, "/R11"}, "wb_reg", 32'(wb_reg), 32'(e_wr));
      chk(wb_data === e_wd, {tag, "/R11"}, "wb_data", wb_data, e_wd);
    end
    chk(st_en === e_se, tag, "st_en", 32'(st_en), 32'(e_se));
    if (e_se) begin
      chk(st_addr === e_sa, tag, "st_addr", st_addr, e_sa);
      chk(st_data === e_sd, tag, "st_data", st_data, e_sd);
    end

    if (e_we) m_rf[e_wr] = e_wd;
    if (e_se) m_dm[e_sa[DAW+1:2]] = e_sd;
    m_pc = npc;
    prev_tag = tag;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      #1;
      step();
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < IMEM_WORDS; i++) m_im[i] = 32'd0;
    for (int i = 0; i < DMEM_WORDS; i++) m_dm[i] = $urandom();
    m_dm[0] = 32'd5;
    m_dm[1] = 32'hFFFF_FFFD;
    m_dm[2] = 32'd5;
    m_dm[3] = 32'h7FFF_FFFF;

    m_im[0]  = itype(6'h23, 5'd0, 5'd1, 16'd0);
    m_im[1]  = itype(6'h23, 5'd0, 5'd2, 16'd4);
    m_im[2]  = itype(6'h23, 5'd0, 5'd3, 16'd8);
    m_im[3]  = itype(6'h23, 5'd0, 5'd0, 16'd12);        // R9 load into register 0
    m_im[4]  = rtype(5'd0, 5'd1, 5'd4, 6'h20);
    m_im[5]  = rtype(5'd2, 5'd1, 5'd5, 6'h2A);          // R3 negative < positive
    m_im[6]  = rtype(5'd1, 5'd2, 5'd6, 6'h2A);
    m_im[7]  = rtype(5'd2, 5'd1, 5'd7, 6'h22);
    m_im[8]  = rtype(5'd2, 5'd3, 5'd8, 6'h24);
    m_im[9]  = rtype(5'd2, 5'd3, 5'd9, 6'h25);
    m_im[10] = itype(6'h2B, 5'd1, 5'd2, 16'hFFF8);      // R5 negative offset, wraps
    m_im[11] = itype(6'h23, 5'd1, 5'd10, 16'hFFF8);     // R4 read back
    m_im[12] = itype(6'h04, 5'd1, 5'd3, 16'd1);         // R6 taken
    m_im[13] = rtype(5'd1, 5'd1, 5'd11, 6'h20);
    m_im[14] = itype(6'h04, 5'd1, 5'd2, 16'd5);         // R6 not taken
    m_im[15] = 32'hFC00_0000;                           // R8 unknown opcode
    m_im[16] = rtype(5'd1, 5'd2, 5'd12, 6'h00);         // R8 unknown function
    m_im[17] = rtype(5'd1, 5'd1, 5'd0, 6'h20);          // R9 write to register 0
    m_im[18] = jtype(26'd20);                           // R7
    m_im[19] = rtype(5'd1, 5'd1, 5'd13, 6'h20);
    m_im[20] = jtype(26'd20);
    start_program(1'b1);
    run(30);

    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < IMEM_WORDS; i++) m_im[i] = rand_word();
      start_program(1'b0);
      run(400);
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule